// File: doc/BRIEF.md
# Attribute Controller Register File

This block holds the attribute register set of a display controller behind a single byte-wide write port. A one-bit phase flip-flop decides how each write is interpreted: in index phase the byte selects a register and carries an output-enable flag; in data phase the byte lands in the selected register. After each write the phase flips.

The set holds the following registers:

- sixteen 6-bit palette entries
- a mode control byte
- a border (overscan) colour
- plane enables with a status multiplexer select
- a horizontal panning value
- a colour select nibble

From the panning value and the display mode class implied by the mode control byte, the block computes a registered pixel-shift amount for the pixel pipeline. A separate clear input returns the flip-flop to index phase, as a status-register read does on the host side. A parameter selects a full configuration or a reduced compatibility configuration.

Top module: `attr_regfile`

## Requirements
- R1: A write in index phase latches wr_data[4:0] as the register index and wr_data[5] as the output-enable flag (`out_en`), and moves the block to data phase (`data_phase`=1).
- R2: A write in data phase updates the register selected by the latched index and returns the block to index phase.
- R3: A data write to index 0..15 stores wr_data[5:0] into that palette entry only while `out_en` is 0; when `out_en` is 1 the entry keeps its value. `pal_rd_data` shows the entry addressed by `pal_rd_idx` one cycle after the address is applied.
- R4: With FULL_CFG=1, index 0x10 stores all 8 bits into `mode_ctl` (bit 0 graphics, bit 2 nine-dot characters, bit 6 eight-bit pixels).
- R5: With FULL_CFG=0, a write to index 0x10 keeps only bits 4:0; bits 7:5 of `mode_ctl` stay 0.
- R6: Index 0x11 stores wr_data[5:0] in `overscan`. Index 0x12 stores wr_data[3:0] in `plane_en` and wr_data[5:4] in `stat_mux`.
- R7: Index 0x13 stores wr_data[3:0] in `pan_raw`.
- R8: Index 0x14 stores wr_data[3:0] in `color_sel` when FULL_CFG=1; with FULL_CFG=0 `color_sel` is always 0.
- R9: `pixel_shift` is registered from `pan_raw` and `mode_ctl`. The mode class is selected in this order: 256-colour (mode bit 0=1 and bit 6=1) gives pan[2:0]>>1; nine-dot text (bit 0=0, bit 2=1) gives pan+1 for pan 0..7 and 0 for pan 8 or above; any other combination gives pan[2:0].
- R10: A data write to an index above 0x14 changes no register, but still returns the block to index phase.
- R11: `idx_clr` forces index phase. A write in the same cycle as `idx_clr` is taken as an index write.
- R12: Synchronous reset clears the phase, index, `out_en`, every control register and `pixel_shift` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write byte (index or data, according to phase) |
| idx_clr | input | 1 | Force the phase flip-flop to index phase |
| pal_rd_idx | input | 4 | Palette read address |
| pal_rd_data | output | 6 | Registered palette entry |
| data_phase | output | 1 | 1 when the next write is a data write |
| out_en | output | 1 | Output-enable flag from the last index write |
| mode_ctl | output | 8 | Mode control register |
| overscan | output | 6 | Border colour |
| plane_en | output | 4 | Plane enables |
| stat_mux | output | 2 | Status multiplexer select |
| pan_raw | output | 4 | Stored panning value |
| color_sel | output | 4 | Colour select |
| pixel_shift | output | 4 | Pixel shift derived from panning and mode class |

## Verification
The assertions assume that reset is applied before the first write. They also assume that `wr_en` and `idx_clr` are clean single-cycle levels, so that every cycle with `wr_en` high is exactly one write. The bench drives every input on the falling edge and holds each write for a single cycle. It leaves two cycles after the final write of a sequence before it samples `pixel_shift`, which settles one register stage after the control registers. It breaks the strict alternation of index and data writes only in the R11 tests, where it uses `idx_clr` on purpose.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int IDX_W       = 5;
  localparam int PAL_LAST    = 15;
  localparam logic [IDX_W-1:0] IDX_MODE  = 5'h10;
  localparam logic [IDX_W-1:0] IDX_BORDER = 5'h11;
  localparam logic [IDX_W-1:0] IDX_PLANE = 5'h12;
  localparam logic [IDX_W-1:0] IDX_PAN   = 5'h13;
  localparam logic [IDX_W-1:0] IDX_CSEL  = 5'h14;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_TEXT9 = 2'd1,
    CLS_256   = 2'd2
  } disp_class_e;
endpackage

// File: rtl/attr_seq.sv
module attr_seq
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             idx_clr,
  output logic             phase,
  output logic             oe_flag,
  output logic [IDX_W-1:0] cur_idx,
  output logic             data_we
);
  logic eff_phase;

  assign eff_phase = phase & ~idx_clr;
  assign data_we   = wr_en & eff_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      oe_flag <= 1'b0;
      cur_idx <= '0;
    end else begin
      phase <= wr_en ? ~eff_phase : eff_phase;
      if (wr_en && !eff_phase) begin
        cur_idx <= wr_data[IDX_W-1:0];
        oe_flag <= wr_data[IDX_W];
      end
    end
  end

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_clr) |=> (phase != $past(phase))); // R2
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (rst)
    (idx_clr && !wr_en) |=> !phase); // R11
  AST_CLR_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (idx_clr && wr_en) |=> phase); // R11
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase && !idx_clr) |=> $stable(cur_idx)); // R1
endmodule

// File: rtl/attr_palette.sv
module attr_palette #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_val,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_val
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_val;
    rd_val <= mem[rd_addr];
  end
endmodule

// File: rtl/attr_pan.sv
module attr_pan
  import attr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] mode,
  input  logic [3:0] pan,
  output logic [3:0] shift
);
  disp_class_e cls;
  logic [3:0]  nxt;

  always_comb begin
    if (mode[0] && mode[6])       cls = CLS_256;
    else if (!mode[0] && mode[2]) cls = CLS_TEXT9;
    else                          cls = CLS_OTHER;
  end

  always_comb begin
    unique case (cls)
      CLS_256:   nxt = {2'b00, pan[2:1]};
      CLS_TEXT9: nxt = pan[3] ? 4'd0 : pan + 4'd1;
      default:   nxt = {1'b0, pan[2:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) shift <= '0;
    else     shift <= nxt;
  end

  AST_SHIFT_256: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_256) |=> (shift <= 4'd3)); // R9
  AST_SHIFT_MAX: assert property (@(posedge clk) disable iff (rst)
    shift <= 4'd8); // R9
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter bit FULL_CFG = 1'b1,
  parameter int PAL_N    = 16,
  parameter int PAL_W    = 6,
  localparam int PAL_AW  = $clog2(PAL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              idx_clr,
  input  logic [PAL_AW-1:0] pal_rd_idx,
  output logic [PAL_W-1:0]  pal_rd_data,
  output logic              data_phase,
  output logic              out_en,
  output logic [7:0]        mode_ctl,
  output logic [5:0]        overscan,
  output logic [3:0]        plane_en,
  output logic [1:0]        stat_mux,
  output logic [3:0]        pan_raw,
  output logic [3:0]        color_sel,
  output logic [3:0]        pixel_shift
);
  localparam logic [7:0] MODE_MASK = FULL_CFG ? 8'hFF : 8'h1F;

  logic             data_we;
  logic [IDX_W-1:0] cur_idx;
  logic             pal_we;

  attr_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .idx_clr (idx_clr),
    .phase   (data_phase),
    .oe_flag (out_en),
    .cur_idx (cur_idx),
    .data_we (data_we)
  );

  assign pal_we = data_we && !out_en && (cur_idx <= IDX_W'(PAL_LAST));

  attr_palette #(.DEPTH(PAL_N), .WIDTH(PAL_W)) u_pal (
    .clk     (clk),
    .we      (pal_we),
    .wr_addr (cur_idx[PAL_AW-1:0]),
    .wr_val  (wr_data[PAL_W-1:0]),
    .rd_addr (pal_rd_idx),
    .rd_val  (pal_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ctl <= '0;
      overscan <= '0;
      plane_en <= '0;
      stat_mux <= '0;
      pan_raw  <= '0;
    end else if (data_we) begin
      case (cur_idx)
        IDX_MODE:   mode_ctl <= wr_data & MODE_MASK;
        IDX_BORDER: overscan <= wr_data[5:0];
        IDX_PLANE: begin
          plane_en <= wr_data[3:0];
          stat_mux <= wr_data[5:4];
        end
        IDX_PAN:    pan_raw <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  generate
    if (FULL_CFG) begin : g_csel
      always_ff @(posedge clk) begin
        if (rst) color_sel <= '0;
        else if (data_we && cur_idx == IDX_CSEL) color_sel <= wr_data[3:0];
      end
    end else begin : g_csel_zero
      assign color_sel = '0;
    end
  endgenerate

  attr_pan u_pan (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode_ctl),
    .pan   (pan_raw),
    .shift (pixel_shift)
  );

  AST_COMPAT_MASK: assert property (@(posedge clk) disable iff (rst)
    !FULL_CFG |-> (mode_ctl[7:5] == 3'b000)); // R5
  AST_CSEL_COMPAT: assert property (@(posedge clk) disable iff (rst)
    !FULL_CFG |-> (color_sel == 4'h0)); // R8
  AST_BORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && data_phase && !idx_clr) |=> $stable(overscan)); // R6
  AST_HIGH_IDX: assert property (@(posedge clk) disable iff (rst)
    (data_we && cur_idx > IDX_CSEL) |=>
      ($stable(mode_ctl) && $stable(overscan) && $stable(pan_raw) && $stable(plane_en))); // R10
endmodule

// File: tb/sim_attr_regfile.sv
module sim_attr_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       idx_clr = 1'b0;
  logic [3:0] pal_rd_idx = '0;
  logic [5:0] pal_q, pal_q1;
  logic       ph, oe, ph1, oe1;
  logic [7:0] mode, mode1;
  logic [5:0] ovs, ovs1;
  logic [3:0] pen, pen1, pan, pan1, csel, csel1, shf, shf1;
  logic [1:0] smx, smx1;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  attr_regfile #(.FULL_CFG(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .idx_clr(idx_clr),
    .pal_rd_idx(pal_rd_idx), .pal_rd_data(pal_q), .data_phase(ph), .out_en(oe),
    .mode_ctl(mode), .overscan(ovs), .plane_en(pen), .stat_mux(smx),
    .pan_raw(pan), .color_sel(csel), .pixel_shift(shf));

  attr_regfile #(.FULL_CFG(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .idx_clr(idx_clr),
    .pal_rd_idx(pal_rd_idx), .pal_rd_data(pal_q1), .data_phase(ph1), .out_en(oe1),
    .mode_ctl(mode1), .overscan(ovs1), .plane_en(pen1), .stat_mux(smx1),
    .pan_raw(pan1), .color_sel(csel1), .pixel_shift(shf1));

  typedef struct packed {
    logic [4:0] idx;
    logic [7:0] val;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 8'h3F, 8'h3F},
    '{5'h05, 8'hFF, 8'h3F},
    '{5'h0F, 8'h2A, 8'h2A},
    '{5'h10, 8'hC5, 8'hC5},
    '{5'h11, 8'hFF, 8'h3F},
    '{5'h12, 8'h35, 8'h35},
    '{5'h13, 8'h1B, 8'h0B},
    '{5'h14, 8'h0E, 8'h0E},
    '{5'h09, 8'h15, 8'h15}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic clr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; idx_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; idx_clr = 1'b0;
  endtask

  task automatic set_reg(input logic [4:0] idx, input logic oeb, input logic [7:0] d);
    wr({2'b00, oeb, idx}, 1'b0);
    wr(d, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] peek(input logic [4:0] idx);
    case (idx)
      5'h10:   return mode;
      5'h11:   return {2'b00, ovs};
      5'h12:   return {2'b00, smx, pen};
      5'h13:   return {4'h0, pan};
      5'h14:   return {4'h0, csel};
      default: return {2'b00, pal_q};
    endcase
  endfunction

  task automatic shift_case(input logic [7:0] m, input logic [3:0] p, input logic [3:0] e);
    set_reg(5'h10, 1'b0, m);
    set_reg(5'h13, 1'b0, {4'h0, p});
    chk("R9 pixel_shift", {4'h0, shf}, {4'h0, e});
  endtask

  initial begin
    repeat (50000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 mode", mode, 8'h00);
    chk("R12 border", {2'b0, ovs}, 8'h00);
    chk("R12 pan/csel", {pan, csel}, 8'h00);
    chk("R12 phase/oe/shift", {2'b0, ph, oe, shf}, 8'h00);

    // table walk: R2 R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      set_reg(VECS[i].idx, 1'b0, VECS[i].val);
      pal_rd_idx = VECS[i].idx[3:0];
      repeat (2) @(negedge clk);
      chk("R2/R3/R4/R6/R7/R8 table", peek(VECS[i].idx), VECS[i].exp);
    end

    // R1 index write latches flag and phase
    wr(8'h25, 1'b0);
    chk("R1 phase/out_en", {6'b0, ph, oe}, 8'h03);
    wr(8'h11, 1'b0);
    repeat (2) @(negedge clk);
    chk("R2 phase back to index", {7'b0, ph}, 8'h00);
    pal_rd_idx = 4'h5;
    repeat (2) @(negedge clk);
    chk("R3 locked palette kept", {2'b0, pal_q}, 8'h3F);

    // R4 / R5 full versus compat mode control
    set_reg(5'h10, 1'b0, 8'hFF);
    chk("R4 full mode", mode, 8'hFF);
    chk("R5 compat mode", mode1, 8'h1F);
    set_reg(5'h14, 1'b0, 8'h0F);
    chk("R8 full csel", {4'h0, csel}, 8'h0F);
    chk("R8 compat csel", {4'h0, csel1}, 8'h00);

    // R9 shift per class
    shift_case(8'h04, 4'h3, 4'h4);
    shift_case(8'h04, 4'h7, 4'h8);
    shift_case(8'h04, 4'h8, 4'h0);
    shift_case(8'h04, 4'hA, 4'h0);
    shift_case(8'h41, 4'h7, 4'h3);
    shift_case(8'h41, 4'hE, 4'h3);
    shift_case(8'h01, 4'hF, 4'h7);
    shift_case(8'h00, 4'h5, 4'h5);
    shift_case(8'h40, 4'h6, 4'h6);

    // R10 high index ignored
    set_reg(5'h11, 1'b0, 8'h21);
    set_reg(5'h15, 1'b0, 8'hFF);
    chk("R10 border kept", {2'b0, ovs}, 8'h21);
    chk("R10 mode kept", mode, 8'h40);
    chk("R10 phase index", {7'b0, ph}, 8'h00);
    set_reg(5'h1F, 1'b0, 8'h00);
    chk("R10 pan kept", {4'h0, pan}, 8'h06);

    // R11 idx_clr alone
    wr(8'h11, 1'b0);
    @(negedge clk); idx_clr = 1'b1;
    @(negedge clk); idx_clr = 1'b0;
    chk("R11 clr phase", {7'b0, ph}, 8'h00);
    wr(8'h11, 1'b0);
    wr(8'h07, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 border after clr", {2'b0, ovs}, 8'h07);
    // R11 clr with concurrent write
    wr(8'h10, 1'b0);
    wr(8'h12, 1'b1);
    chk("R11 concurrent index phase", {7'b0, ph}, 8'h01);
    wr(8'h0F, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 plane after concurrent", {2'b0, smx, pen}, 8'h0F);
    chk("R11 mode untouched", mode, 8'h40);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule